// File: doc/BRIEF.md
# Hot-Swap Pad Isolation Controller for a Parallel Disk Port

This block sits between a parallel disk port's controller core and its pads, and decides what the pads see while a drive is being pulled out or plugged in. A two-bit mode code picks one of three pad states. In normal operation the core's output enables, output values and input data pass through. In float mode every output is released and every input is forced to zero. In sink mode every output is enabled and driven low, so that charge left on the cable drains away, and the inputs are again forced to zero.

A timing word holds one ready-sampling enable bit per drive. For the drive that the current cycle addresses, a cleared bit tells the cycle logic not to wait for the ready line. Software clears this bit before it isolates the port. Accesses to the missing drive then finish at once and read back zeros, so nothing waits for a ready signal that will never come. A mode code that is written while a transfer is in flight is not applied until the transfer flag drops, because changing the pads in the middle of a transfer can hang the bus.

All outputs are registered. Pad controls, gated input data and the ready qualification are each produced one clock after the inputs they depend on. A new mode code, accepted while no transfer is running, reaches the pads two clocks after it is presented.

Top module: `pata_swap_iso`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `pad_oe_o`, `pad_out_o`, `core_in_o` and `iordy_ok_o` are all zero, and the mode is normal.
- R2: With mode code 00b (normal), `pad_oe_o` and `pad_out_o` equal `core_oe_i` and `core_out_i` from one clock earlier, and `core_in_o` equals `pad_in_i` from one clock earlier.
- R3: With mode code 01b (float), `pad_oe_o` is all zeros, `pad_out_o` is all zeros and `core_in_o` is all zeros, whatever the core and pad inputs are.
- R4: With mode code 10b (sink), `pad_oe_o` is all ones, `pad_out_o` is all zeros and `core_in_o` is all zeros.
- R5: Mode code 11b is reserved and behaves exactly like 00b.
- R6: The mode register takes `sig_mode_i` only on a clock where `xfer_busy_i` is low. While `xfer_busy_i` is high, the mode in force does not change, and a pending code is applied on the first clock after the flag drops.
- R7: The ready-sampling enable bit of drive d is bit 4*d+1 of `timing_i` (bit 1 for drive 0, bit 5 for drive 1). The bit that is used is the one for the drive that `drv_sel_i` selects.
- R8: When the selected drive's sampling enable bit is 0, `iordy_ok_o` is 1 one clock later, whatever `pad_iordy_i` and the mode are.
- R9: When the selected drive's sampling enable bit is 1, `iordy_ok_o` one clock later equals `pad_iordy_i` in normal mode and is 0 in float or sink mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_mode_i | input | 2 | Requested pad mode code (00 normal, 01 float, 10 sink, 11 normal) |
| xfer_busy_i | input | 1 | High while a transfer is in progress; holds off mode changes |
| timing_i | input | 4*NUM_DRIVES | Timing word; bit 4*d+1 is the ready-sampling enable of drive d |
| drv_sel_i | input | SEL_W | Drive addressed by the current cycle |
| core_oe_i | input | PAD_OUT_W | Output enables from the controller core |
| core_out_i | input | PAD_OUT_W | Output values from the controller core |
| pad_in_i | input | PAD_IN_W | Raw data from the input pads |
| pad_iordy_i | input | 1 | Raw ready line from the pad |
| pad_oe_o | output | PAD_OUT_W | Registered output enables to the pads |
| pad_out_o | output | PAD_OUT_W | Registered output values to the pads |
| core_in_o | output | PAD_IN_W | Registered, gated input data to the core |
| iordy_ok_o | output | 1 | Registered: the cycle may proceed without waiting further |

## Verification
The bench builds the block with two drives, an 8-bit output pad group and a 16-bit input pad group. Two drives make both enable positions, bit 1 and bit 5 of the timing word, reachable, so a wrong bit position or a wrong drive selection shows up. The narrow output group makes the all-ones pattern of sink mode easy to tell apart from data that is passed through. The 16-bit input group lets random pad data show up in normal mode and be seen forced to zero in float and sink modes.

// File: rtl/swap_iso_pkg.sv
package swap_iso_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_FLOAT  = 2'b01,
    PM_SINK   = 2'b10
  } pad_mode_e;

  // 11b is reserved and falls back to normal pass-through
  function automatic pad_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b01:   return PM_FLOAT;
      2'b10:   return PM_SINK;
      default: return PM_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/swap_mode_ctrl.sv
module swap_mode_ctrl
  import swap_iso_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_code_i,
  input  logic       xfer_busy_i,
  output pad_mode_e  mode_o
);

  // A new code is only taken between transfers; otherwise it waits.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= PM_NORMAL;
    end else if (!xfer_busy_i) begin
      mode_o <= decode_mode(mode_code_i);
    end
  end

endmodule

// File: rtl/swap_out_gate.sv
module swap_out_gate
  import swap_iso_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  pad_mode_e    mode_i,
  input  logic [W-1:0] core_oe_i,
  input  logic [W-1:0] core_out_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o
);

  for (genvar b = 0; b < W; b++) begin : g_pad
    logic oe_nxt;
    logic out_nxt;

    always_comb begin
      case (mode_i)
        PM_FLOAT: begin oe_nxt = 1'b0;          out_nxt = 1'b0;           end
        PM_SINK:  begin oe_nxt = 1'b1;          out_nxt = 1'b0;           end
        default:  begin oe_nxt = core_oe_i[b];  out_nxt = core_out_i[b]; end
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe_o[b]  <= 1'b0;
        pad_out_o[b] <= 1'b0;
      end else begin
        pad_oe_o[b]  <= oe_nxt;
        pad_out_o[b] <= out_nxt;
      end
    end
  end

endmodule

// File: rtl/swap_in_gate.sv
module swap_in_gate
  import swap_iso_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  pad_mode_e    mode_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] core_in_o
);

  logic pass;
  assign pass = (mode_i == PM_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      core_in_o <= '0;
    end else begin
      core_in_o <= pass ? pad_in_i : '0;
    end
  end

endmodule

// File: rtl/swap_iordy_qual.sv
module swap_iordy_qual
  import swap_iso_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  localparam int TMG_W = 4 * NUM_DRIVES,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  pad_mode_e        mode_i,
  input  logic [TMG_W-1:0] timing_i,
  input  logic [SEL_W-1:0] drv_sel_i,
  input  logic             pad_iordy_i,
  output logic             iordy_ok_o
);

  logic [NUM_DRIVES-1:0] sample_en;

  // Each drive owns a nibble of the timing word; its enable is bit 1 of it.
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    assign sample_en[d] = timing_i[4*d+1];
  end

  logic sel_en;
  logic ready_seen;
  assign sel_en     = sample_en[drv_sel_i];
  assign ready_seen = pad_iordy_i && (mode_i == PM_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      iordy_ok_o <= 1'b0;
    end else begin
      iordy_ok_o <= !sel_en || ready_seen;
    end
  end

endmodule

// File: rtl/pata_swap_iso.sv
module pata_swap_iso
  import swap_iso_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int PAD_OUT_W  = 24,
  parameter int PAD_IN_W   = 16,
  localparam int TMG_W = 4 * NUM_DRIVES,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           sig_mode_i,
  input  logic                 xfer_busy_i,
  input  logic [TMG_W-1:0]     timing_i,
  input  logic [SEL_W-1:0]     drv_sel_i,
  input  logic [PAD_OUT_W-1:0] core_oe_i,
  input  logic [PAD_OUT_W-1:0] core_out_i,
  input  logic [PAD_IN_W-1:0]  pad_in_i,
  input  logic                 pad_iordy_i,
  output logic [PAD_OUT_W-1:0] pad_oe_o,
  output logic [PAD_OUT_W-1:0] pad_out_o,
  output logic [PAD_IN_W-1:0]  core_in_o,
  output logic                 iordy_ok_o
);

  pad_mode_e mode_q;

  swap_mode_ctrl u_mode (
    .clk         (clk),
    .rst         (rst),
    .mode_code_i (sig_mode_i),
    .xfer_busy_i (xfer_busy_i),
    .mode_o      (mode_q)
  );

  swap_out_gate #(.W(PAD_OUT_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_q),
    .core_oe_i  (core_oe_i),
    .core_out_i (core_out_i),
    .pad_oe_o   (pad_oe_o),
    .pad_out_o  (pad_out_o)
  );

  swap_in_gate #(.W(PAD_IN_W)) u_in (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_q),
    .pad_in_i  (pad_in_i),
    .core_in_o (core_in_o)
  );

  swap_iordy_qual #(.NUM_DRIVES(NUM_DRIVES)) u_rdy (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_q),
    .timing_i    (timing_i),
    .drv_sel_i   (drv_sel_i),
    .pad_iordy_i (pad_iordy_i),
    .iordy_ok_o  (iordy_ok_o)
  );

endmodule

// File: rtl/swap_iso_chk.sv
module swap_iso_chk
  import swap_iso_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int OUT_W = 24,
  parameter int IN_W  = 16,
  localparam int TMG_W = 4 * NUM_DRIVES,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_busy_i,
  input logic [TMG_W-1:0] timing_i,
  input logic [SEL_W-1:0] drv_sel_i,
  input pad_mode_e        mode_q,
  input logic [OUT_W-1:0] pad_oe_o,
  input logic [OUT_W-1:0] pad_out_o,
  input logic [IN_W-1:0]  core_in_o,
  input logic             iordy_ok_o
);

  logic sel_en;
  assign sel_en = timing_i[4*int'(drv_sel_i)+1];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pad_oe_o == '0 && pad_out_o == '0 && core_in_o == '0 && !iordy_ok_o));

  // R3
  float_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_FLOAT) |=> (pad_oe_o == '0 && pad_out_o == '0 && core_in_o == '0));

  // R4
  sink_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_SINK) |=> (pad_oe_o == '1 && pad_out_o == '0 && core_in_o == '0));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_busy_i |=> (mode_q == $past(mode_q)));

  // R8
  ready_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_en |=> iordy_ok_o);

  // R9
  isolated_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_en && mode_q != PM_NORMAL) |=> !iordy_ok_o);

endmodule

bind pata_swap_iso swap_iso_chk #(
  .NUM_DRIVES (NUM_DRIVES),
  .OUT_W      (PAD_OUT_W),
  .IN_W       (PAD_IN_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .xfer_busy_i (xfer_busy_i),
  .timing_i    (timing_i),
  .drv_sel_i   (drv_sel_i),
  .mode_q      (mode_q),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o),
  .core_in_o   (core_in_o),
  .iordy_ok_o  (iordy_ok_o)
);

// File: tb/pata_swap_iso_tb_top.sv
module pata_swap_iso_tb_top;

  localparam int ND = 2;
  localparam int OW = 8;
  localparam int IW = 16;
  localparam int TW = 4 * ND;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    sig_mode = 2'b00;
  logic          busy = 1'b0;
  logic [TW-1:0] tmg = '0;
  logic          sel = 1'b0;
  logic [OW-1:0] c_oe = '0;
  logic [OW-1:0] c_out = '0;
  logic [IW-1:0] p_in = '0;
  logic          p_rdy = 1'b0;
  logic [OW-1:0] pad_oe;
  logic [OW-1:0] pad_out;
  logic [IW-1:0] core_in;
  logic          rdy_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pata_swap_iso #(.NUM_DRIVES(ND), .PAD_OUT_W(OW), .PAD_IN_W(IW)) dut_i (
    .clk(clk), .rst(rst), .sig_mode_i(sig_mode), .xfer_busy_i(busy),
    .timing_i(tmg), .drv_sel_i(sel), .core_oe_i(c_oe), .core_out_i(c_out),
    .pad_in_i(p_in), .pad_iordy_i(p_rdy), .pad_oe_o(pad_oe),
    .pad_out_o(pad_out), .core_in_o(core_in), .iordy_ok_o(rdy_ok)
  );

  // Bench model state: 0 normal, 1 float, 2 sink
  int       m_mode = 0;
  logic [1:0] m_code = 2'b00;

  function automatic int dec(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
  endfunction

  function automatic string mode_tag(input int m, input logic [1:0] c);
    if (m == 1) return "R3";
    if (m == 2) return "R4";
    return (c == 2'b11) ? "R5" : "R2";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // One clock: expectations from the values driven now, compared after the edge.
  task automatic step();
    logic [OW-1:0] e_oe, e_out;
    logic [IW-1:0] e_in;
    logic e_rdy, en;
    string mt, rt;
    bit deferred;
    if (rst) begin
      e_oe = '0; e_out = '0; e_in = '0; e_rdy = 1'b0;
      mt = "R1"; rt = "R1";
    end else begin
      e_oe  = (m_mode == 0) ? c_oe : (m_mode == 2) ? '1 : '0;
      e_out = (m_mode == 0) ? c_out : '0;
      e_in  = (m_mode == 0) ? p_in : '0;
      en    = tmg[4*int'(sel)+1];
      e_rdy = !en || (p_rdy && m_mode == 0);
      mt = mode_tag(m_mode, m_code);
      rt = en ? "R9_R7" : "R8_R7";
    end
    deferred = 0;
    if (rst) begin
      m_mode = 0; m_code = 2'b00;
    end else if (!busy) begin
      m_mode = dec(sig_mode); m_code = sig_mode;
    end else if (dec(sig_mode) != m_mode) begin
      deferred = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(mt, "pad_oe", 32'(pad_oe), 32'(e_oe));
    chk(mt, "pad_out", 32'(pad_out), 32'(e_out));
    chk(mt, "core_in", 32'(core_in), 32'(e_in));
    chk(rt, "iordy_ok", 32'(rdy_ok), 32'(e_rdy));
    if (deferred) chk("R6", "held_mode", 32'(m_mode == dec(m_code)), 32'd1);
  endtask

  task automatic rand_data();
    c_oe  = OW'($urandom);
    c_out = OW'($urandom);
    p_in  = IW'($urandom);
    p_rdy = 1'($urandom);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: outputs cleared during reset
    rand_data(); tmg = '1;
    step(); step();
    rst = 1'b0;
    // R2: normal pass-through
    sig_mode = 2'b00; tmg = 8'h22;
    repeat (4) begin rand_data(); step(); end
    // R3: float
    sig_mode = 2'b01;
    repeat (4) begin rand_data(); c_oe = '1; p_in = '1; step(); end
    // R4: sink
    sig_mode = 2'b10;
    repeat (4) begin rand_data(); step(); end
    // R5: reserved code behaves as normal
    sig_mode = 2'b11;
    repeat (4) begin rand_data(); step(); end
    // R6: code change while busy is held off, then applied
    sig_mode = 2'b00; step();
    busy = 1'b1; sig_mode = 2'b10;
    repeat (5) begin rand_data(); step(); end
    busy = 1'b0;
    repeat (3) begin rand_data(); step(); end
    // R7: drive 1 enabled only by bit 5, drive 0 by bit 1
    sig_mode = 2'b00; tmg = 8'h20; p_rdy = 1'b0; sel = 1'b1; step(); step();
    sel = 1'b0; step();
    tmg = 8'h02; sel = 1'b1; step();
    sel = 1'b0; step();
    // R9: enabled, isolated mode waits even with ready high
    sig_mode = 2'b01; tmg = 8'h02; p_rdy = 1'b1; step(); step(); step();
    // R8: disabled bypass while isolated
    tmg = 8'hDD; p_rdy = 1'b0; step(); step();
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      rand_data();
      if ($urandom_range(7) == 0) sig_mode = 2'($urandom);
      busy = ($urandom_range(9) < 3);
      tmg  = TW'($urandom);
      sel  = 1'($urandom);
      if ($urandom_range(199) == 0) rst = 1'b1; else rst = 1'b0;
      step();
    end
    rst = 1'b0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule